// File: doc/BRIEF.md
# Memory access sequencer

The sequencer shares one memory port among three requesters: a video engine, a coprocessor group and the CPU. When the port is idle it grants the highest-ranked pending requester. It then counts out a setup phase and an access phase whose length depends on the address region and on whether a DRAM access stays inside the currently open page. When the count ends it returns read data from a behavioural backing store, or commits write data to it.

Each requester drives its own request, address, write-enable and write-data. It holds them until it sees its done pulse. The CPU can mark a request as an instruction prefetch. Setup cycles that elapsed while the port sat idle before such a request are then credited, which models setup running ahead while the current instruction word executes. A fetch without the prefetch flag, such as a literal fetched in the middle of a word, always pays the full setup.

Top module: `memseq_top`

## Requirements
- R1: Requester index 0 (video) outranks index 1 (coprocessor), which outranks index 2 (CPU). When several requests are pending in an idle cycle, the lowest index is granted, and at most one grant is high at a time.
- R2: A grant is never withdrawn before its done pulse. A higher-ranked request that arrives during an access waits and wins the next arbitration.
- R3: Address bit 20 set selects the upper region (SRAM, boot ROM, I/O, configuration). Its access phase is 6 cycles.
- R4: Address bit 20 clear selects DRAM. The page is address bits 19:10. The access phase is 28 cycles when the page equals the open page and 70 cycles otherwise.
- R5: The open page is invalid after reset and is loaded only by granted DRAM accesses. Upper-region accesses leave it untouched.
- R6: The setup phase is 4 cycles. Video, coprocessor and non-prefetch CPU accesses always pay all of it. The done pulse lands in cycle N after the grant edge, where N is the setup plus the access phase and the first cycle with the grant high counts as cycle 1.
- R7: For a CPU request with cpu_pf_i high, the setup is shortened by the number of idle cycles, capped at 4, in which no request was pending, counted from the end of the previous access to the grant.
- R8: done_o is a one-cycle pulse to the granted requester. On a read, rdata_o holds the store word at address bits 9:0 in that cycle. On a write, that word takes the owner's write data. The store is zero after reset.
- R9: cpu_stall_o is high whenever the CPU request is high and the CPU done pulse is not.
- R10: During reset all grants, done pulses and the stall output are low.
- R11: A grant becomes visible in the cycle after the idle cycle in which the request is seen. The cycle after a done pulse is always idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Requests: 0 video, 1 coprocessor, 2 CPU |
| addr_i | input | 3x21 | Word address per requester |
| we_i | input | 3 | Write enable per requester |
| wdata_i | input | 3x20 | Write data per requester |
| cpu_pf_i | input | 1 | CPU request is an instruction prefetch |
| gnt_o | output | 3 | Grant, one-hot or zero |
| done_o | output | 3 | Completion pulse per requester |
| rdata_o | output | 20 | Read data, valid with done |
| cpu_stall_o | output | 1 | CPU waiting for its access |

## Verification
Single accesses walk through an off-page DRAM access, an on-page DRAM access and an upper-region access, plus a DRAM access right after an upper-region one. This separates the three latencies and shows that the open page survives the upper region. CPU prefetches issued after idle gaps of 0, 2 and 7 cycles, next to a plain fetch after the same gap, separate credited setup from full setup and show the cap. All three requesters raised in one cycle, and a video request arriving in the middle of a CPU access, separate fixed priority from pre-emption. A seeded random mix of requesters, gaps, regions, pages and writes then compares every latency and every read word against a bench model.

// File: rtl/memseq_pkg.sv
`timescale 1ns/1ps
package memseq_pkg;
  localparam int NREQ    = 3;
  localparam int REQ_VID = 0;
  localparam int REQ_COP = 1;
  localparam int REQ_CPU = 2;

  typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;
endpackage

// File: rtl/memseq_arb.sv
`timescale 1ns/1ps
module memseq_arb #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/memseq_ctrl.sv
`timescale 1ns/1ps
module memseq_ctrl
  import memseq_pkg::*;
#(
  parameter int N         = 3,
  parameter int HW        = 11,
  parameter int SETUP_CYC = 4,
  parameter int SRAM_CYC  = 6,
  parameter int HIT_CYC   = 28,
  parameter int MISS_CYC  = 70,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 any_i,
  input  logic [IW-1:0]        idx_i,
  input  logic [N-1:0][HW-1:0] hi_i,
  input  logic                 cpu_pf_i,
  output logic [N-1:0]         gnt_o,
  output logic [N-1:0]         done_o,
  output logic [IW-1:0]        owner_o
);
  localparam int CW = $clog2(SETUP_CYC + MISS_CYC + 1);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam int PW = HW - 1;

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] setup_q;
  logic [IW-1:0] owner_q;
  logic          pg_vld_q;
  logic [PW-1:0] pg_q;

  logic [HW-1:0] sel_hi;
  logic          sel_dram, sel_hit;
  logic [CW-1:0] lat_c, load_c;
  logic [SW-1:0] credit_c;

  assign sel_hi   = hi_i[idx_i];
  assign sel_dram = ~sel_hi[HW-1];
  assign sel_hit  = pg_vld_q && (pg_q == sel_hi[PW-1:0]);

  always_comb begin
    if (!sel_dram)    lat_c = CW'(SRAM_CYC);
    else if (sel_hit) lat_c = CW'(HIT_CYC);
    else              lat_c = CW'(MISS_CYC);
    // idle setup credit only for CPU prefetch
    credit_c = (idx_i == IW'(REQ_CPU) && cpu_pf_i) ? setup_q : '0;
    load_c   = CW'(SETUP_CYC) - CW'(credit_c) + lat_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      setup_q  <= '0;
      owner_q  <= '0;
      pg_vld_q <= 1'b0;
      pg_q     <= '0;
    end else if (st_q == ST_IDLE) begin
      if (any_i) begin
        st_q    <= ST_BUSY;
        owner_q <= idx_i;
        cnt_q   <= load_c;
        setup_q <= '0;
        if (sel_dram) begin
          pg_vld_q <= 1'b1;
          pg_q     <= sel_hi[PW-1:0];
        end
      end else if (setup_q != SW'(SETUP_CYC)) begin
        setup_q <= setup_q + 1'b1;
      end
    end else begin
      setup_q <= '0;
      if (cnt_q == CW'(1)) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign gnt_o[g]  = (st_q == ST_BUSY) && (owner_q == IW'(g));
    assign done_o[g] = gnt_o[g] && (cnt_q == CW'(1));
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/memseq_store.sv
`timescale 1ns/1ps
module memseq_store #(
  parameter int DW  = 20,
  parameter int MAW = 10,
  localparam int DEPTH = 1 << MAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [MAW-1:0] idx_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/memseq_top.sv
`timescale 1ns/1ps
module memseq_top
  import memseq_pkg::*;
#(
  parameter int AW        = 21,
  parameter int DW        = 20,
  parameter int PAGE_LSB  = 10,
  parameter int SETUP_CYC = 4,
  parameter int SRAM_CYC  = 6,
  parameter int HIT_CYC   = 28,
  parameter int MISS_CYC  = 70
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NREQ-1:0]        req_i,
  input  logic [NREQ-1:0][AW-1:0] addr_i,
  input  logic [NREQ-1:0]        we_i,
  input  logic [NREQ-1:0][DW-1:0] wdata_i,
  input  logic                   cpu_pf_i,
  output logic [NREQ-1:0]        gnt_o,
  output logic [NREQ-1:0]        done_o,
  output logic [DW-1:0]          rdata_o,
  output logic                   cpu_stall_o
);
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam int HW  = AW - PAGE_LSB;
  localparam int MAW = PAGE_LSB;

  logic [IW-1:0]          arb_idx, owner;
  logic                   arb_any;
  logic [NREQ-1:0][HW-1:0] hi;

  for (genvar g = 0; g < NREQ; g++) begin : g_hi
    assign hi[g] = addr_i[g][AW-1:PAGE_LSB];
  end

  memseq_arb #(.N(NREQ)) i_arb (
    .req_i (req_i),
    .idx_o (arb_idx),
    .any_o (arb_any)
  );

  memseq_ctrl #(
    .N(NREQ), .HW(HW), .SETUP_CYC(SETUP_CYC), .SRAM_CYC(SRAM_CYC),
    .HIT_CYC(HIT_CYC), .MISS_CYC(MISS_CYC)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_i    (arb_any),
    .idx_i    (arb_idx),
    .hi_i     (hi),
    .cpu_pf_i (cpu_pf_i),
    .gnt_o    (gnt_o),
    .done_o   (done_o),
    .owner_o  (owner)
  );

  memseq_store #(.DW(DW), .MAW(MAW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    ((|done_o) && we_i[owner]),
    .idx_i   (addr_i[owner][MAW-1:0]),
    .wdata_i (wdata_i[owner]),
    .rdata_o (rdata_o)
  );

  assign cpu_stall_o = req_i[REQ_CPU] && !done_o[REQ_CPU];
endmodule

// File: rtl/memseq_chk.sv
`timescale 1ns/1ps
module memseq_chk
  import memseq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NREQ-1:0] req_i,
  input logic [NREQ-1:0] gnt_o,
  input logic [NREQ-1:0] done_o,
  input logic            cpu_stall_o
);
  // R1
  cpu_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gnt_o[REQ_CPU]) |-> $past(!req_i[REQ_VID] && !req_i[REQ_COP]));

  // R1
  single_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  for (genvar g = 0; g < NREQ; g++) begin : g_hold
    // R2
    keep_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[g] && !done_o[g]) |=> gnt_o[g]);
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> (done_o == '0));

  // R11
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> (gnt_o == '0));

  // R9
  stall_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> req_i[REQ_CPU]);
endmodule

bind memseq_top memseq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .gnt_o       (gnt_o),
  .done_o      (done_o),
  .cpu_stall_o (cpu_stall_o)
);

// File: tb/test_memseq_top.sv
`timescale 1ns/1ps
module test_memseq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]       req = '0;
  logic [2:0][20:0] addr = '0;
  logic [2:0]       we = '0;
  logic [2:0][19:0] wdata = '0;
  logic             pf = 1'b0;
  logic [2:0]       gnt, done;
  logic [19:0]      rdata;
  logic             stall;

  memseq_top i_memseq_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .cpu_pf_i(pf), .gnt_o(gnt), .done_o(done),
    .rdata_o(rdata), .cpu_stall_o(stall)
  );

  int errs = 0, chks = 0;
  logic [19:0] mdl [1024];
  bit pg_v = 0;
  logic [9:0] pg = '0;
  int idle_cnt = 0;
  int cyc [3];
  int expn [3];
  bit trk [3];
  string tag [3];
  int ord [$];
  logic [2:0] prev_done = '0;
  bit finished = 0;

  task automatic chk(bit ok, string r, int act, int exp_v);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp_v);
    end
  endtask

  function automatic int access_len(logic [20:0] a, bit hit_v);
    if (a[20]) return 6;
    return hit_v ? 28 : 70;
  endfunction

  function automatic int credit_of(int idle);
    int c;
    c = (idle > 0) ? idle - 1 : 0;
    return (c > 4) ? 4 : c;
  endfunction

  // reference model and protocol monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(gnt == 0 && done == 0 && stall == 0, "R10 reset outputs", {gnt, done, stall}, 0);
      for (int i = 0; i < 1024; i++) mdl[i] = '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (gnt[i] && !trk[i]) begin
          bit h;
          int cr;
          h  = !addr[i][20] && pg_v && (pg == addr[i][19:10]);
          cr = (i == 2 && pf) ? credit_of(idle_cnt) : 0;
          expn[i] = 4 - cr + access_len(addr[i], h);
          tag[i]  = addr[i][20] ? "R3" : (h ? "R4 hit" : "R4/R5 miss");
          tag[i]  = {tag[i], (cr > 0) ? " R7 latency" : " R6 latency"};
          if (!addr[i][20]) begin
            pg_v = 1;
            pg   = addr[i][19:10];
          end
          if (i == 2) chk(req[1:0] == 0, "R1 cpu granted over higher rank", req, 0);
          if (i == 1) chk(req[0] == 0, "R1 coprocessor granted over video", req, 0);
          trk[i] = 1;
          cyc[i] = 1;
        end else if (gnt[i]) begin
          cyc[i]++;
        end else if (trk[i]) begin
          chk(1'b0, "R2 grant withdrawn before done", 0, 1);
          trk[i] = 0;
        end
      end
      if (|prev_done) chk(done == 0, "R8 done longer than one cycle", done, 0);
      for (int i = 0; i < 3; i++) begin
        if (done[i]) begin
          chk(cyc[i] == expn[i], tag[i], cyc[i], expn[i]);
          if (we[i]) mdl[addr[i][9:0]] = wdata[i];
          else chk(rdata == mdl[addr[i][9:0]], "R8 read data", rdata, mdl[addr[i][9:0]]);
          trk[i] = 0;
          req[i] <= 1'b0;
          ord.push_back(i);
        end
      end
      chk(stall == (req[2] && !done[2]), "R9 cpu stall", stall, req[2] && !done[2]);
      if (|done) idle_cnt = 0;
      else if (gnt == 0) idle_cnt++;
      prev_done = done;
    end
  end

  task automatic issue(int i, logic [20:0] a, bit w, logic [19:0] d);
    addr[i]  = a;
    we[i]    = w;
    wdata[i] = d;
    req[i]   = 1'b1;
  endtask

  task automatic wait_quiet();
    do begin
      @(negedge clk);
      #1;
    end while (req != 0);
  endtask

  task automatic gap(int g);
    repeat (g) @(negedge clk);
    #1;
  endtask

  function automatic logic [20:0] rnd_addr();
    int r;
    r = $urandom % 3;
    if (r == 0) return 21'h100000 | 21'($urandom % 1024);
    return 21'((($urandom % 3) << 10) | ($urandom % 1024));
  endfunction

  initial begin
    #2000000;
    if (!finished) begin
      errs++;
      chks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3; i++) begin
      trk[i] = 0;
      cyc[i] = 0;
      expn[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    gap(2);

    // R5 first DRAM access is off-page
    issue(0, 21'h00400, 0, 0);            wait_quiet();
    // R4 same page
    issue(0, 21'h00455, 1, 20'hABCDE);    wait_quiet();
    // R3 upper region, aliased read of the word just written (R8)
    issue(1, 21'h100055, 0, 0);           wait_quiet();
    // R5 upper region left the open page alone
    issue(1, 21'h007FF, 0, 0);            wait_quiet();
    issue(1, 21'h00800, 0, 0);            wait_quiet();
    // R7 prefetch credit after gaps 0, 2, 7
    pf = 1;
    issue(2, 21'h00810, 0, 0);            wait_quiet();
    gap(2); issue(2, 21'h00811, 0, 0);    wait_quiet();
    gap(7); issue(2, 21'h00812, 0, 0);    wait_quiet();
    // R6 non-prefetch pays full setup
    pf = 0;
    gap(7); issue(2, 21'h00813, 0, 0);    wait_quiet();

    // R1 all three at once
    ord.delete();
    issue(2, 21'h00820, 0, 0);
    issue(1, 21'h100100, 1, 20'h12345);
    issue(0, 21'h00821, 0, 0);
    wait_quiet();
    chk(ord.size() == 3 && ord[0] == 0 && ord[1] == 1 && ord[2] == 2,
        "R1 service order", (ord.size() == 3) ? ord[0]*100 + ord[1]*10 + ord[2] : -1, 12);

    // R2 video arrives during CPU access
    ord.delete();
    issue(2, 21'h00900, 0, 0);
    gap(5);
    issue(0, 21'h00901, 0, 0);
    wait_quiet();
    chk(ord.size() == 2 && ord[0] == 2 && ord[1] == 0,
        "R2 no pre-emption", (ord.size() == 2) ? ord[0]*10 + ord[1] : -1, 20);

    // random mix
    for (int n = 0; n < 90; n++) begin
      int mode;
      mode = $urandom % 4;
      pf = 1'($urandom % 2);
      if (mode == 0) begin
        logic [2:0] m;
        m = 3'($urandom % 7) + 3'd1;
        for (int i = 0; i < 3; i++)
          if (m[i]) issue(i, rnd_addr(), 1'($urandom % 2), 20'($urandom));
      end else begin
        issue($urandom % 3, rnd_addr(), 1'($urandom % 2), 20'($urandom));
      end
      wait_quiet();
      gap($urandom % 7);
    end

    gap(3);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule